// File: doc/BRIEF.md
# World-Tagged Translation Lookaside Buffer

This block is a small fully associative address-translation cache for a processor core that alternates between a secure world and a normal world. Every entry records the world that created it, so translations of both worlds stay resident at the same time. Switching worlds therefore does not empty the cache. A lookup presents a virtual page number together with a one-bit world tag, where 1 means normal and 0 means secure. On a hit, the block returns the physical page number and the non-secure memory attribute in the same cycle.

On a miss, the block stalls the lookup and raises a request on a valid/ready page-walk port. The request carries the virtual page and the world tag. It then waits for the walk response and installs the returned translation. The held lookup then hits on the following cycle. When the normal world creates an entry, the stored non-secure attribute is always 1, whatever value the walker returns. A secure-world entry keeps the returned attribute, so secure code can map normal memory. A full flush and a flush limited to one world let the monitor discard translations on a world switch.

Top module: `wtlb_top`

## Requirements
- R1: When `req_valid` is high, no walk is in progress, and a valid entry has the same virtual page and world tag as the request, `resp_valid` is high in that same cycle, with that entry's `resp_ppn` and `resp_ns`. At most one entry ever matches a lookup.
- R2: An entry hits only for lookups whose world tag (`req_world`, 1 = normal, 0 = secure) equals the tag it was installed with. A secure entry and a normal entry for the same virtual page can both be resident, and each returns its own translation.
- R3: An entry installed for the normal world (tag 1) always returns `resp_ns` = 1, even when the walk response supplied 0.
- R4: An entry installed for the secure world (tag 0) returns exactly the attribute the walk response supplied, either 0 or 1.
- R5: A lookup that misses leads to `walk_req_valid` = 1 on the next cycle, with `walk_req_vpn` and `walk_req_world` equal to the lookup's page and tag. A lookup that hits never raises `walk_req_valid`.
- R6: While `walk_req_valid` is high and `walk_req_ready` is low, the request stays asserted and its fields stay unchanged. `resp_valid` stays low from the miss until the cycle after the cycle in which `walk_rsp_valid` is accepted; in that next cycle the held lookup returns the installed translation.
- R7: A refill writes the lowest-indexed invalid entry. When all entries are valid, it writes the entry named by a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such eviction.
- R8: A one-cycle pulse on `flush_all` invalidates every entry, so the next lookup of any page misses.
- R9: A one-cycle pulse on `flush_world` invalidates exactly the entries whose tag equals `flush_world_sel`. Entries of the other world keep hitting.
- R10: A synchronous reset (`rst_n` low at a clock edge) invalidates every entry and returns the walk port to idle. After reset, `resp_valid` and `walk_req_valid` are low and the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request, held until `resp_valid` |
| req_vpn | input | VPN_W | Virtual page number of the lookup |
| req_world | input | 1 | World tag of the lookup (1 normal, 0 secure) |
| resp_valid | output | 1 | Lookup answered this cycle |
| resp_ppn | output | PPN_W | Physical page number of the answer |
| resp_ns | output | 1 | Non-secure attribute of the answer |
| walk_req_valid | output | 1 | Page-walk request |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | VPN_W | Page to walk |
| walk_req_world | output | 1 | World tag of the walk |
| walk_rsp_valid | input | 1 | Walk result available |
| walk_rsp_ppn | input | PPN_W | Walked physical page |
| walk_rsp_ns | input | 1 | Walked non-secure attribute |
| flush_all | input | 1 | Invalidate all entries |
| flush_world | input | 1 | Invalidate entries of one world |
| flush_world_sel | input | 1 | World tag selected by `flush_world` |

## Verification
The assertions check four things on every cycle. At most one entry matches any lookup. A normal-world answer always carries the non-secure attribute. A miss is followed by a walk request that holds steady until it is accepted, and no answer appears while the walk request is up. A full flush leaves nothing to hit. The bench scenarios cover what needs a history of installs. These are the coexistence of secure and normal entries for the same page, and the exact attribute kept by secure entries. They also include which entry the rotating pointer evicts once the table is full, the survival of the other world's entries across a per-world flush, and the empty table after a mid-run reset.

// File: rtl/wtlb_pkg.sv
package wtlb_pkg;
  localparam logic WORLD_SECURE = 1'b0;
  localparam logic WORLD_NORMAL = 1'b1;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_REQ  = 2'd1,
    WALK_WAIT = 2'd2
  } walk_state_e;

  // Attribute stored for a new entry: normal-world entries are always non-secure.
  function automatic logic stored_ns(input logic world, input logic walked_ns);
    return (world == WORLD_NORMAL) ? 1'b1 : walked_ns;
  endfunction
endpackage

// File: rtl/wtlb_store.sv
module wtlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [VPN_W-1:0]            lk_vpn,
  input  logic                        lk_world,
  input  logic                        flush_all,
  input  logic                        flush_world,
  input  logic                        flush_sel,
  input  logic                        wr_en,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [VPN_W-1:0]            wr_vpn,
  input  logic                        wr_world,
  input  logic [PPN_W-1:0]            wr_ppn,
  input  logic                        wr_ns,
  output logic [ENTRIES-1:0]          valid_vec,
  output logic [ENTRIES-1:0]          hit_vec,
  output logic [PPN_W-1:0]            hit_ppn,
  output logic                        hit_ns
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic               world_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [ENTRIES];
  logic               ns_q    [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all || (flush_world && (world_q[i] == flush_sel)))
          valid_q[i] <= 1'b0;
        if (wr_en && (wr_idx == IDX_W'(i)))
          valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        vpn_q[i]   <= wr_vpn;
        world_q[i] <= wr_world;
        ppn_q[i]   <= wr_ppn;
        ns_q[i]    <= wr_ns;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_match
      assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (world_q[g] == lk_world);
    end
  endgenerate

  always_comb begin
    hit_ppn = '0;
    hit_ns  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn = hit_ppn | (ppn_q[i] & {PPN_W{hit_vec[i]}});
      hit_ns  = hit_ns  | (ns_q[i] & hit_vec[i]);
    end
  end

  assign valid_vec = valid_q;
endmodule

// File: rtl/wtlb_victim.sv
module wtlb_victim #(
  parameter int ENTRIES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ENTRIES-1:0]          valid_vec,
  input  logic                        install,
  output logic [$clog2(ENTRIES)-1:0]  victim_idx,
  output logic                        table_full
);
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [IDX_W-1:0] lowest_free(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!v[i]) idx = IDX_W'(i);
    return idx;
  endfunction

  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0] rr_q;

  assign table_full = &valid_vec;
  assign victim_idx = table_full ? rr_q : lowest_free(valid_vec);

  always_ff @(posedge clk) begin
    if (!rst_n)
      rr_q <= '0;
    else if (install && table_full)
      rr_q <= next_slot(rr_q);
  end
endmodule

// File: rtl/wtlb_walk_ctrl.sv
module wtlb_walk_ctrl
  import wtlb_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic             miss_world,
  input  logic             walk_req_ready,
  input  logic             walk_rsp_valid,
  output logic             idle,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  output logic             walk_req_world,
  output logic             install
);
  walk_state_e      state_q;
  logic [VPN_W-1:0] vpn_q;
  logic             world_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      vpn_q   <= '0;
      world_q <= WORLD_SECURE;
    end else begin
      unique case (state_q)
        WALK_IDLE: if (miss) begin
          state_q <= WALK_REQ;
          vpn_q   <= miss_vpn;
          world_q <= miss_world;
        end
        WALK_REQ:  if (walk_req_ready) state_q <= WALK_WAIT;
        WALK_WAIT: if (walk_rsp_valid) state_q <= WALK_IDLE;
        default:   state_q <= WALK_IDLE;
      endcase
    end
  end

  assign idle           = (state_q == WALK_IDLE);
  assign walk_req_valid = (state_q == WALK_REQ);
  assign walk_req_vpn   = vpn_q;
  assign walk_req_world = world_q;
  assign install        = (state_q == WALK_WAIT) && walk_rsp_valid;
endmodule

// File: rtl/wtlb_top.sv
module wtlb_top
  import wtlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_world,
  output logic             resp_valid,
  output logic [PPN_W-1:0] resp_ppn,
  output logic             resp_ns,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_req_vpn,
  output logic             walk_req_world,
  input  logic             walk_rsp_valid,
  input  logic [PPN_W-1:0] walk_rsp_ppn,
  input  logic             walk_rsp_ns,
  input  logic             flush_all,
  input  logic             flush_world,
  input  logic             flush_world_sel
);
  localparam int IDX_W = $clog2(ENTRIES);

  // Named internal events, observed by the bound checker.
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] hit_vec;
  logic               lookup_hit;
  logic               miss_evt;
  logic               install_evt;
  logic               walk_idle;
  logic [IDX_W-1:0]   victim_idx;
  logic               table_full;
  logic [PPN_W-1:0]   hit_ppn;
  logic               hit_ns;

  assign lookup_hit = |hit_vec;
  assign resp_valid = req_valid && walk_idle && lookup_hit;
  assign miss_evt   = req_valid && walk_idle && !lookup_hit;
  assign resp_ppn   = hit_ppn;
  assign resp_ns    = hit_ns;

  wtlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_vpn      (req_vpn),
    .lk_world    (req_world),
    .flush_all   (flush_all),
    .flush_world (flush_world),
    .flush_sel   (flush_world_sel),
    .wr_en       (install_evt),
    .wr_idx      (victim_idx),
    .wr_vpn      (walk_req_vpn),
    .wr_world    (walk_req_world),
    .wr_ppn      (walk_rsp_ppn),
    .wr_ns       (stored_ns(walk_req_world, walk_rsp_ns)),
    .valid_vec   (valid_vec),
    .hit_vec     (hit_vec),
    .hit_ppn     (hit_ppn),
    .hit_ns      (hit_ns)
  );

  wtlb_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .install    (install_evt),
    .victim_idx (victim_idx),
    .table_full (table_full)
  );

  wtlb_walk_ctrl #(.VPN_W(VPN_W)) walk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss           (miss_evt),
    .miss_vpn       (req_vpn),
    .miss_world     (req_world),
    .walk_req_ready (walk_req_ready),
    .walk_rsp_valid (walk_rsp_valid),
    .idle           (walk_idle),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .walk_req_world (walk_req_world),
    .install        (install_evt)
  );
endmodule

// File: rtl/wtlb_chk.sv
module wtlb_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_world,
  input logic               resp_valid,
  input logic               resp_ns,
  input logic               walk_req_valid,
  input logic               walk_req_ready,
  input logic [VPN_W-1:0]   walk_req_vpn,
  input logic               walk_req_world,
  input logic               flush_all,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               lookup_hit,
  input logic               miss_evt,
  input logic               install_evt
);
  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R3
  normal_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && req_world) |-> resp_ns);

  // R5
  miss_walks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> walk_req_valid);

  // R5
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !walk_req_valid);

  // R6
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=>
      (walk_req_valid && $stable(walk_req_vpn) && $stable(walk_req_world)));

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !resp_valid);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !install_evt) |=> !lookup_hit);
endmodule

bind wtlb_top wtlb_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_world      (req_world),
  .resp_valid     (resp_valid),
  .resp_ns        (resp_ns),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .walk_req_vpn   (walk_req_vpn),
  .walk_req_world (walk_req_world),
  .flush_all      (flush_all),
  .hit_vec        (hit_vec),
  .lookup_hit     (lookup_hit),
  .miss_evt       (miss_evt),
  .install_evt    (install_evt)
);

// File: tb/wtlb_top_tb_top.sv
module wtlb_top_tb_top;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic             req_world = 1'b0;
  logic             resp_valid;
  logic [PPN_W-1:0] resp_ppn;
  logic             resp_ns;
  logic             walk_req_valid;
  logic             walk_req_ready = 1'b0;
  logic [VPN_W-1:0] walk_req_vpn;
  logic             walk_req_world;
  logic             walk_rsp_valid = 1'b0;
  logic [PPN_W-1:0] walk_rsp_ppn = '0;
  logic             walk_rsp_ns = 1'b0;
  logic             flush_all = 1'b0;
  logic             flush_world = 1'b0;
  logic             flush_world_sel = 1'b0;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [PPN_W-1:0] ppn;
    logic             ns;
    string            tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #4 clk = ~clk;

  wtlb_top #(.ENTRIES(8), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_world(req_world),
    .resp_valid(resp_valid), .resp_ppn(resp_ppn), .resp_ns(resp_ns),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_req_vpn(walk_req_vpn), .walk_req_world(walk_req_world),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_ns(walk_rsp_ns),
    .flush_all(flush_all), .flush_world(flush_world), .flush_world_sel(flush_world_sel)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected attribute, restated from R3/R4.
  function automatic logic want_ns(input logic world, input logic walked);
    if (world) return 1'b1;
    return walked;
  endfunction

  // Monitor: pops the scoreboard whenever an answer appears.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && resp_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R1 unexpected answer", resp_ppn, 0);
        end else begin
          exp_item_t e;
          e = sb_q.pop_front();
          check(resp_ppn == e.ppn, {e.tag, " ppn"}, resp_ppn, e.ppn);
          check(resp_ns == e.ns, {e.tag, " ns"}, resp_ns, e.ns);
        end
      end
    end
  end

  // Driver: one lookup; on an expected miss it also plays the walker.
  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic world, input bit exp_miss,
                        input logic [PPN_W-1:0] ppn, input logic ns, input string tag);
    exp_item_t e;
    e.ppn = ppn;
    e.ns  = exp_miss ? want_ns(world, ns) : ns;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn; req_world = world;
    #2;
    if (!exp_miss) begin
      check(resp_valid == 1'b1, {tag, " R1 hit answers"}, resp_valid, 1);
      check(walk_req_valid == 1'b0, {tag, " R5 no walk"}, walk_req_valid, 0);
      @(negedge clk); req_valid = 1'b0; #2;
      check(walk_req_valid == 1'b0, {tag, " R5 no walk after hit"}, walk_req_valid, 0);
    end else begin
      check(resp_valid == 1'b0, {tag, " R6 miss stalls"}, resp_valid, 0);
      @(negedge clk); #2;
      check(walk_req_valid == 1'b1, {tag, " R5 walk raised"}, walk_req_valid, 1);
      check(walk_req_vpn == vpn, {tag, " R5 walk vpn"}, walk_req_vpn, vpn);
      check(walk_req_world == world, {tag, " R5 walk world"}, walk_req_world, world);
      @(negedge clk); #2;
      check(walk_req_valid == 1'b1 && walk_req_vpn == vpn, {tag, " R6 walk held"}, walk_req_vpn, vpn);
      walk_req_ready = 1'b1;
      @(negedge clk); walk_req_ready = 1'b0; #2;
      check(walk_req_valid == 1'b0 && resp_valid == 1'b0, {tag, " R6 waiting"}, resp_valid, 0);
      @(negedge clk);
      walk_rsp_valid = 1'b1; walk_rsp_ppn = ppn; walk_rsp_ns = ns;
      @(negedge clk);
      walk_rsp_valid = 1'b0; #2;
      check(resp_valid == 1'b1, {tag, " R6 answer after refill"}, resp_valid, 1);
      @(negedge clk); req_valid = 1'b0;
    end
  endtask

  task automatic pulse_flush(input bit all, input logic sel);
    @(negedge clk);
    flush_all = all; flush_world = !all; flush_world_sel = sel;
    @(negedge clk);
    flush_all = 1'b0; flush_world = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2;
    check(resp_valid == 1'b0 && walk_req_valid == 1'b0, "R10 reset outputs", resp_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(walk_req_valid == 1'b0, "R10 idle after reset", walk_req_valid, 0);

    lookup(20'h10, 1'b0, 1, 20'h100, 1'b0, "R10/R4 first secure fill");  // entry 0
    lookup(20'h10, 1'b0, 0, 20'h100, 1'b0, "R1 secure hit");
    lookup(20'h10, 1'b1, 1, 20'h200, 1'b0, "R2/R3 normal fill ns forced"); // entry 1
    lookup(20'h10, 1'b0, 0, 20'h100, 1'b0, "R2 secure coexists");
    lookup(20'h10, 1'b1, 0, 20'h200, 1'b1, "R3 normal hit ns");
    lookup(20'h20, 1'b0, 1, 20'h300, 1'b1, "R4 secure maps normal memory"); // entry 2
    lookup(20'h20, 1'b0, 0, 20'h300, 1'b1, "R4 secure ns kept");

    pulse_flush(0, 1'b1);
    lookup(20'h10, 1'b0, 0, 20'h100, 1'b0, "R9 secure survives");
    lookup(20'h20, 1'b0, 0, 20'h300, 1'b1, "R9 secure survives 2");
    lookup(20'h10, 1'b1, 1, 20'h201, 1'b1, "R9 normal flushed");       // entry 1

    pulse_flush(1, 1'b0);
    lookup(20'h20, 1'b0, 1, 20'h301, 1'b0, "R8 all flushed");          // entry 0
    lookup(20'h10, 1'b1, 1, 20'h202, 1'b1, "R8 normal flushed too");   // entry 1

    // Fill entries 2..7 with secure pages 0x32..0x37.
    for (int i = 2; i < 8; i++)
      lookup(VPN_W'(32'h30 + i), 1'b0, 1, PPN_W'(32'h400 + i), 1'b0, "R7 fill");
    lookup(20'h20, 1'b0, 0, 20'h301, 1'b0, "R7 entry0 still present");
    lookup(20'h40, 1'b0, 1, 20'h500, 1'b0, "R7 evict slot0");          // replaces 0x20
    lookup(20'h41, 1'b0, 1, 20'h501, 1'b0, "R7 evict slot1");          // replaces normal 0x10
    lookup(20'h32, 1'b0, 0, 20'h402, 1'b0, "R7 slot2 kept");
    lookup(20'h40, 1'b0, 0, 20'h500, 1'b0, "R7 new entry hits");
    lookup(20'h10, 1'b1, 1, 20'h203, 1'b1, "R7 slot1 was evicted");    // replaces slot2 (0x32)
    lookup(20'h20, 1'b0, 1, 20'h302, 1'b0, "R7 slot0 was evicted");    // replaces slot3 (0x33)
    lookup(20'h34, 1'b0, 0, 20'h404, 1'b0, "R7 slot4 kept");

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lookup(20'h40, 1'b0, 1, 20'h600, 1'b0, "R10 reset empties table");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R1 all answers seen", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule